// File: doc/BRIEF.md
# Bundled-Data to Dual-Rail Word Converter

This block accepts words of a configurable width from a sender that uses a four-phase bundled-data channel. That channel has a group of plain data wires, a request wire and an acknowledge wire, and the sender sets the data before it raises its request. The block re-sends each word on a four-phase dual-rail channel. On that channel every bit travels on a pair of rails, and a single acknowledge wire comes back from the receiver.

The converter takes the word at the clock edge where it first sees the request high. At that same edge it loads the dual-rail code of every bit into flops, so the output word goes from all-neutral to all-valid in one step. It then waits for the receiver's acknowledge, returns every rail to neutral in one step, and waits for that acknowledge to drop. Only after this does it raise its own input acknowledge and finish the return-to-zero half of the input handshake. At most one word is in flight between the two ends. The model is fully synchronous; matching the delay of the bundle against its request is left to the surrounding design.

Top module: `bd2dr_conv`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `in_ack` is 0 and every rail pair is neutral (`out_zero` = 0, `out_one` = 0).
- R2: The word emitted is the value on `in_data` at the first rising clock edge where `in_req` is seen high in the idle state. Changes on `in_data` at any other time have no effect on the rails.
- R3: The bit code is as follows: (`out_zero[i]`, `out_one[i]`) = (0,0) means neutral, (1,0) means logic 0 and (0,1) means logic 1.
- R4: No bit ever shows the pattern (`out_zero[i]`, `out_one[i]`) = (1,1).
- R5: The output word is always either entirely neutral or entirely valid. No partly valid word ever appears.
- R6: A valid word holds stable while `out_ack` is low. In the cycle after `out_ack` is sampled high, every rail is neutral.
- R7: The rails stay neutral until the next request. `in_ack` rises exactly one cycle after `out_ack` is sampled low following the neutral phase, and never while `out_ack` is still high.
- R8: `in_ack` stays high while `in_req` is high. It falls one cycle after `in_req` is sampled low.
- R9: While `in_ack` is high the rails are neutral, so no second word starts before the input handshake has fully completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_req | input | 1 | Bundled-data request from the sender |
| in_data | input | WIDTH | Bundled data word |
| in_ack | output | 1 | Acknowledge to the bundled-data sender |
| out_zero | output | WIDTH | Rail .0 of each bit (high means logic 0) |
| out_one | output | WIDTH | Rail .1 of each bit (high means logic 1) |
| out_ack | input | 1 | Acknowledge from the dual-rail receiver |

## Verification
A control state that skips a phase shows up at the ports within one cycle. Examples are `in_ack` rising while the rails are still valid, or rails that stay valid after the acknowledge has been seen. A rail flop that loads at the wrong edge, or loads a shifted bit, shows up in the first cycle of the valid phase. The checks there compare the rails with a word that has already been overwritten on `in_data`. A stuck handshake shows up as `in_ack` failing to follow `in_req` down, one cycle after the sender releases its request.

// File: rtl/bd2dr_pkg.sv
package bd2dr_pkg;

    // Gray-ordered handshake phases: each step flips one state bit.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'b00,
        PH_VALID = 2'b01,
        PH_NULL  = 2'b11,
        PH_DONE  = 2'b10
    } conv_phase_e;

    typedef struct packed {
        logic zero;
        logic one;
    } rail_pair_t;

    localparam rail_pair_t RAIL_NEUTRAL = '{zero: 1'b0, one: 1'b0};

    function automatic rail_pair_t encode_bit(input logic b);
        rail_pair_t p;
        p.zero = ~b;
        p.one  = b;
        return p;
    endfunction

endpackage

// File: rtl/bd2dr_ctrl.sv
module bd2dr_ctrl
    import bd2dr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_req,
    input  logic out_ack,
    output logic load_word,
    output logic clear_word,
    output logic in_ack
);

    conv_phase_e phase_q, phase_d;

    always_comb begin
        phase_d    = phase_q;
        load_word  = 1'b0;
        clear_word = 1'b0;
        unique case (phase_q)
            PH_IDLE: begin
                if (in_req) begin
                    load_word = 1'b1;
                    phase_d   = PH_VALID;
                end
            end
            PH_VALID: begin
                if (out_ack) begin
                    clear_word = 1'b1;
                    phase_d    = PH_NULL;
                end
            end
            PH_NULL: begin
                if (!out_ack) phase_d = PH_DONE;
            end
            PH_DONE: begin
                if (!in_req) phase_d = PH_IDLE;
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH_IDLE;
        else     phase_q <= phase_d;
    end

    assign in_ack = (phase_q == PH_DONE);

endmodule

// File: rtl/bd2dr_rail_cell.sv
module bd2dr_rail_cell
    import bd2dr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic clear,
    input  logic bit_in,
    output logic rail_zero,
    output logic rail_one
);

    rail_pair_t pair_q;

    always_ff @(posedge clk) begin
        if (rst || clear) pair_q <= RAIL_NEUTRAL;
        else if (load)    pair_q <= encode_bit(bit_in);
    end

    assign rail_zero = pair_q.zero;
    assign rail_one  = pair_q.one;

endmodule

// File: rtl/bd2dr_rail_bank.sv
module bd2dr_rail_bank #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             clear,
    input  logic [WIDTH-1:0] word_in,
    output logic [WIDTH-1:0] rail_zero,
    output logic [WIDTH-1:0] rail_one
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        bd2dr_rail_cell u_cell (
            .clk      (clk),
            .rst      (rst),
            .load     (load),
            .clear    (clear),
            .bit_in   (word_in[i]),
            .rail_zero(rail_zero[i]),
            .rail_one (rail_one[i])
        );
    end

endmodule

// File: rtl/bd2dr_conv.sv
module bd2dr_conv #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_req,
    input  logic [WIDTH-1:0] in_data,
    output logic             in_ack,
    output logic [WIDTH-1:0] out_zero,
    output logic [WIDTH-1:0] out_one,
    input  logic             out_ack
);

    logic load_word;
    logic clear_word;

    bd2dr_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .in_req    (in_req),
        .out_ack   (out_ack),
        .load_word (load_word),
        .clear_word(clear_word),
        .in_ack    (in_ack)
    );

    bd2dr_rail_bank #(.WIDTH(WIDTH)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .load     (load_word),
        .clear    (clear_word),
        .word_in  (in_data),
        .rail_zero(out_zero),
        .rail_one (out_one)
    );

endmodule

// File: rtl/bd2dr_conv_chk.sv
module bd2dr_conv_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             in_req,
    input logic             in_ack,
    input logic             out_ack,
    input logic [WIDTH-1:0] out_zero,
    input logic [WIDTH-1:0] out_one
);

    logic neutral;
    logic full;
    assign neutral = ((out_zero | out_one) == '0);
    assign full    = ((out_zero | out_one) == '1);

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!in_ack && neutral));

    assert_no_double_rail_R4: assert property (@(posedge clk) disable iff (rst)
        (out_zero & out_one) == '0);

    assert_word_coherent_R5: assert property (@(posedge clk) disable iff (rst)
        neutral || full);

    assert_valid_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (full && !out_ack) |=> ($stable(out_zero) && $stable(out_one)));

    assert_release_after_ack_R6: assert property (@(posedge clk) disable iff (rst)
        (full && out_ack) |=> neutral);

    assert_ack_order_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(in_ack) |-> (!$past(out_ack) && $past(neutral)));

    assert_ack_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (in_ack && in_req) |=> in_ack);

    assert_ack_drop_R8: assert property (@(posedge clk) disable iff (rst)
        (in_ack && !in_req) |=> !in_ack);

    assert_no_valid_during_ack_R9: assert property (@(posedge clk) disable iff (rst)
        in_ack |-> neutral);

endmodule

bind bd2dr_conv bd2dr_conv_chk #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .in_req  (in_req),
    .in_ack  (in_ack),
    .out_ack (out_ack),
    .out_zero(out_zero),
    .out_one (out_one)
);

// File: tb/bd2dr_conv_test.sv
module bd2dr_conv_test;

    localparam int WIDTH      = 8;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_req = 1'b0;
    logic [WIDTH-1:0] in_data = '0;
    logic             in_ack;
    logic [WIDTH-1:0] out_zero;
    logic [WIDTH-1:0] out_one;
    logic             out_ack = 1'b0;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bd2dr_conv #(.WIDTH(WIDTH)) uut (
        .clk(clk), .rst(rst), .in_req(in_req), .in_data(in_data),
        .in_ack(in_ack), .out_zero(out_zero), .out_one(out_one),
        .out_ack(out_ack)
    );

    // Expected rail .0 / rail .1 for a data word (R3: 0 -> (1,0), 1 -> (0,1)).
    function automatic logic [WIDTH-1:0] exp_zero(input logic [WIDTH-1:0] d);
        return ~d;
    endfunction
    function automatic logic [WIDTH-1:0] exp_one(input logic [WIDTH-1:0] d);
        return d;
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [2*WIDTH-1:0] act, input logic [2*WIDTH-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_neutral(input string req);
        check((out_zero == '0) && (out_one == '0), req,
              {out_zero, out_one}, '0);
    endtask

    task automatic check_word(input logic [WIDTH-1:0] d, input string req);
        check((out_zero == exp_zero(d)) && (out_one == exp_one(d))
              && ((out_zero & out_one) == '0),
              req, {out_zero, out_one}, {exp_zero(d), exp_one(d)});
    endtask

    task automatic check_ack(input logic e, input string req);
        check(in_ack === e, req, {{(2*WIDTH-1){1'b0}}, in_ack},
              {{(2*WIDTH-1){1'b0}}, e});
    endtask

    task automatic send_word(input logic [WIDTH-1:0] d, input int ack_wait,
                             input int ack_hold, input int req_hold);
        @(negedge clk);
        in_data = d;
        in_req  = 1'b1;
        @(negedge clk);
        check_word(d, "R2 R3 word taken at request");
        check_ack(1'b0, "R9 no ack while valid");
        in_data = ~d;
        for (int k = 0; k < ack_wait; k++) begin
            @(negedge clk);
            check_word(d, "R6 R2 valid word stable, data change ignored");
        end
        out_ack = 1'b1;
        @(negedge clk);
        check_neutral("R6 neutral after out_ack");
        check_ack(1'b0, "R7 no in_ack while out_ack high");
        for (int k = 0; k < ack_hold; k++) begin
            in_data = WIDTH'($urandom);
            @(negedge clk);
            check_neutral("R7 neutral held, R4 R5 no partial code");
            check_ack(1'b0, "R7 in_ack waits for out_ack low");
        end
        out_ack = 1'b0;
        @(negedge clk);
        check_ack(1'b1, "R7 in_ack rises after out_ack low");
        check_neutral("R9 neutral while in_ack high");
        for (int k = 0; k < req_hold; k++) begin
            @(negedge clk);
            check_ack(1'b1, "R8 in_ack held while in_req high");
            check_neutral("R9 no new word while in_ack high");
        end
        in_req = 1'b0;
        @(negedge clk);
        check_ack(1'b0, "R8 in_ack falls after in_req low");
        check_neutral("R7 neutral in idle");
    endtask

    initial begin
        void'($urandom(32'd1234));
        in_req = 1'b1;
        in_data = 8'hA5;
        repeat (3) @(negedge clk);
        check_ack(1'b0, "R1 in_ack low in reset");
        check_neutral("R1 rails neutral in reset");
        in_req = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        check_ack(1'b0, "R1 in_ack low after reset");
        check_neutral("R1 rails neutral after reset");

        // Idle data wiggle without request has no effect (R2).
        for (int k = 0; k < 4; k++) begin
            in_data = WIDTH'($urandom);
            @(negedge clk);
            check_neutral("R2 idle data ignored");
        end

        send_word('0, 0, 0, 0);
        send_word('1, 1, 2, 1);
        send_word(8'h55, 3, 0, 2);
        send_word(8'hAA, 0, 1, 0);
        send_word(8'h01, 2, 2, 2);
        send_word(8'h80, 0, 0, 3);

        for (int n = 0; n < 60; n++) begin
            send_word(WIDTH'($urandom), int'($urandom % 4),
                      int'($urandom % 3), int'($urandom % 3));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule